// File: doc/BRIEF.md
# Prioritized Bus Address Window Translator

This block translates addresses issued on a local bus into addresses for a PCI-style bus. It holds three programmable windows. Each window is described by a pair of registers: a base register that gives the local address range, the window size and an enable bit, and a map register that gives the upper bits of the translated address and, where the window allows it, the cycle type. A local address is presented with a valid strobe. The block compares it against every enabled window and takes the lowest-indexed window that matches. One clock later it returns the translated address, the cycle type (memory, I/O or configuration) and the index of the winning window, or it raises a miss flag.

Windows may overlap. Software relies on the fixed priority to hide a higher window behind a lower one. For example, it grows window 0 from 256 MB to 512 MB so that it covers the range of window 1. Window 1 can then be reprogrammed as a 16 MB configuration aperture and later put back. Windows 0 and 1 produce memory or configuration cycles. The I/O window, index 2 by default, always produces I/O cycles. A configuration translation passes the device, function and register fields of the offset through unchanged and forces the two lowest address bits to zero.

Top module: `addr_window_xlate`

## Requirements
- R1: After reset every window is disabled and all outputs are zero. Every request then misses until software programs and enables a window.
- R2: Base register layout: bits [31:12] hold the window base and bit 8 enables the window. Bits [4:0] hold n, the log2 of the window size, and any n below 12 is treated as 12. A request hits when the window is enabled and the address matches the base in every bit from n upward.
- R3: The translated address is made of the map register bits from n upward and the request address bits below n. Map bits below 12 never reach the translated address.
- R4: When more than one enabled window matches, the lowest-indexed window supplies the response. Writing a base or map register has no effect on the other windows.
- R5: rsp_kind encodes 01 memory, 10 I/O, 11 configuration and 00 none. The I/O window (index 2) always gives 10. Windows 0 and 1 give 11 when map bit 0 is 1 and 01 when it is 0.
- R6: For a configuration translation, rsp_addr[1:0] is 00. The offset bits above bit 1, which carry the device in [15:11], the function in [10:8] and the register in [7:2], pass through unchanged.
- R7: On a miss, rsp_miss is 1 and rsp_kind, rsp_addr and rsp_win are all 0.
- R8: rsp_valid is req_valid delayed by one clock. The response fields hold their values in cycles that follow a clock with no request.
- R9: A register write takes effect at the clock edge that samples it. A request sampled at that same edge is translated with the old register contents.
- R10: A write with cfg_win equal to 3, which is not a window, changes no window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_win | input | 2 | Window index of the write |
| cfg_is_map | input | 1 | 1 selects the map register, 0 the base register |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Local address valid |
| req_addr | input | 32 | Local address |
| rsp_valid | output | 1 | Response valid, one clock after the request |
| rsp_addr | output | 32 | Translated bus address |
| rsp_kind | output | 2 | Cycle type: 00 none, 01 memory, 10 I/O, 11 configuration |
| rsp_miss | output | 1 | No enabled window matched |
| rsp_win | output | 2 | Index of the winning window |

## Verification
Each response is due exactly one clock after the edge that samples its request. A register write changes translations starting with the request sampled at the following edge. The bench drives inputs on the falling edge. It checks a directed request at the next falling edge, after exactly one rising edge has passed, against literal values taken from the requirements. A behavioural model, updated at each rising edge from the sampled inputs, is compared with every output on every falling edge. This also covers the held values in idle cycles and the old-value rule when a write and a request share an edge.

// File: rtl/addr_xlate_pkg.sv
package addr_xlate_pkg;

   // cycle type reported on rsp_kind
   typedef enum logic [1:0] {
      KIND_NONE = 2'b00,
      KIND_MEM  = 2'b01,
      KIND_IO   = 2'b10,
      KIND_CFG  = 2'b11
   } xl_kind_e;

   // base register field positions
   localparam int unsigned BASE_EN_BIT  = 8;
   localparam int unsigned BASE_SZ_LSB  = 0;
   // map register field position selecting configuration cycles
   localparam int unsigned MAP_CFG_BIT  = 0;

endpackage

// File: rtl/addr_window_regs.sv
module addr_window_regs
   import addr_xlate_pkg::*;
#(
   parameter int unsigned NUM_WIN = 3,
   parameter int unsigned ADDR_W  = 32,
   localparam int unsigned IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             we,
   input  logic [IDX_W-1:0]                 win,
   input  logic                             is_map,
   input  logic [ADDR_W-1:0]                wdata,
   output logic [NUM_WIN-1:0][ADDR_W-1:0]   base_q,
   output logic [NUM_WIN-1:0][ADDR_W-1:0]   map_q
);

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
      logic sel;
      assign sel = we && (win == IDX_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_q[i] <= '0;
            map_q[i]  <= '0;
         end else if (sel) begin
            if (is_map) map_q[i]  <= wdata;
            else        base_q[i] <= wdata;
         end
      end
   end

endmodule

// File: rtl/addr_window_match.sv
module addr_window_match
   import addr_xlate_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned MIN_LOG2 = 12,
   parameter bit          IS_IO    = 1'b0,
   localparam int unsigned SZ_W    = $clog2(ADDR_W)
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] map,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [ADDR_W-1:0] xaddr,
   output logic [1:0]        kind
);

   logic [SZ_W-1:0]   sz_code;
   logic [SZ_W-1:0]   sz_eff;
   logic [ADDR_W-1:0] mask;
   logic [ADDR_W-1:0] joined;
   logic              is_cfg;

   assign sz_code = base[BASE_SZ_LSB +: SZ_W];
   assign sz_eff  = (sz_code < SZ_W'(MIN_LOG2)) ? SZ_W'(MIN_LOG2) : sz_code;
   assign mask    = {ADDR_W{1'b1}} << sz_eff;
   assign hit     = base[BASE_EN_BIT] && ((addr & mask) == (base & mask));
   assign joined  = (map & mask) | (addr & ~mask);

   if (IS_IO) begin : g_io
      assign is_cfg = 1'b0;
      assign kind   = KIND_IO;
   end else begin : g_mem
      assign is_cfg = map[MAP_CFG_BIT];
      assign kind   = is_cfg ? KIND_CFG : KIND_MEM;
   end

   assign xaddr = is_cfg ? {joined[ADDR_W-1:2], 2'b00} : joined;

endmodule

// File: rtl/addr_window_prio.sv
module addr_window_prio
   import addr_xlate_pkg::*;
#(
   parameter int unsigned NUM_WIN = 3,
   parameter int unsigned ADDR_W  = 32,
   localparam int unsigned IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
   input  logic [NUM_WIN-1:0]             hit,
   input  logic [NUM_WIN-1:0][ADDR_W-1:0] xaddr,
   input  logic [NUM_WIN-1:0][1:0]        kind,
   output logic                           any,
   output logic [IDX_W-1:0]               sel,
   output logic [ADDR_W-1:0]              addr,
   output logic [1:0]                     sel_kind
);

   // scan from the top so the lowest matching index is written last
   always_comb begin
      any      = 1'b0;
      sel      = '0;
      addr     = '0;
      sel_kind = KIND_NONE;
      for (int i = NUM_WIN - 1; i >= 0; i--) begin
         if (hit[i]) begin
            any      = 1'b1;
            sel      = IDX_W'(i);
            addr     = xaddr[i];
            sel_kind = kind[i];
         end
      end
   end

endmodule

// File: rtl/addr_window_xlate.sv
module addr_window_xlate
   import addr_xlate_pkg::*;
#(
   parameter int unsigned NUM_WIN  = 3,
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned MIN_LOG2 = 12,
   parameter int unsigned IO_WIN   = 2,
   localparam int unsigned IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_win,
   input  logic              cfg_is_map,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic [1:0]        rsp_kind,
   output logic              rsp_miss,
   output logic [IDX_W-1:0]  rsp_win
);

   if (NUM_WIN < 1) begin : g_bad_num
      $error("NUM_WIN must be at least 1");
   end
   if (IO_WIN >= NUM_WIN) begin : g_bad_io
      $error("IO_WIN must index an existing window");
   end
   if (MIN_LOG2 <= BASE_EN_BIT || MIN_LOG2 >= ADDR_W) begin : g_bad_min
      $error("MIN_LOG2 must lie above the enable bit and below ADDR_W");
   end
   if (BASE_EN_BIT < $clog2(ADDR_W)) begin : g_bad_en
      $error("enable bit overlaps the size field");
   end

   logic [NUM_WIN-1:0][ADDR_W-1:0] base_q;
   logic [NUM_WIN-1:0][ADDR_W-1:0] map_q;
   logic [NUM_WIN-1:0]             hit_vec;
   logic [NUM_WIN-1:0][ADDR_W-1:0] xaddr_vec;
   logic [NUM_WIN-1:0][1:0]        kind_vec;
   logic                           any_hit;
   logic [IDX_W-1:0]               win_sel;
   logic [ADDR_W-1:0]              addr_sel;
   logic [1:0]                     kind_sel;

   addr_window_regs #(
      .NUM_WIN (NUM_WIN),
      .ADDR_W  (ADDR_W)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cfg_we),
      .win    (cfg_win),
      .is_map (cfg_is_map),
      .wdata  (cfg_wdata),
      .base_q (base_q),
      .map_q  (map_q)
   );

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_match
      addr_window_match #(
         .ADDR_W   (ADDR_W),
         .MIN_LOG2 (MIN_LOG2),
         .IS_IO    (i == IO_WIN)
      ) u_match (
         .base  (base_q[i]),
         .map   (map_q[i]),
         .addr  (req_addr),
         .hit   (hit_vec[i]),
         .xaddr (xaddr_vec[i]),
         .kind  (kind_vec[i])
      );
   end

   addr_window_prio #(
      .NUM_WIN (NUM_WIN),
      .ADDR_W  (ADDR_W)
   ) u_prio (
      .hit      (hit_vec),
      .xaddr    (xaddr_vec),
      .kind     (kind_vec),
      .any      (any_hit),
      .sel      (win_sel),
      .addr     (addr_sel),
      .sel_kind (kind_sel)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_addr  <= '0;
         rsp_kind  <= KIND_NONE;
         rsp_miss  <= 1'b0;
         rsp_win   <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_addr <= addr_sel;
            rsp_kind <= kind_sel;
            rsp_miss <= !any_hit;
            rsp_win  <= win_sel;
         end
      end
   end

endmodule

// File: rtl/addr_window_xlate_chk.sv
module addr_window_xlate_chk
   import addr_xlate_pkg::*;
#(
   parameter int unsigned NUM_WIN = 3,
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned IO_WIN  = 2,
   localparam int unsigned IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic [NUM_WIN-1:0]  hit_vec,
   input logic                rsp_valid,
   input logic [ADDR_W-1:0]   rsp_addr,
   input logic [1:0]          rsp_kind,
   input logic                rsp_miss,
   input logic [IDX_W-1:0]    rsp_win
);

   logic               armed;
   logic               req_d;
   logic [NUM_WIN-1:0] hit_d;
   logic [NUM_WIN-1:0] below;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed <= 1'b0;
         req_d <= 1'b0;
         hit_d <= '0;
      end else begin
         armed <= 1'b1;
         req_d <= req_valid;
         hit_d <= hit_vec;
      end
   end

   assign below = (NUM_WIN'(1) << rsp_win) - NUM_WIN'(1);

   // R8: valid is the request strobe one clock later
   p_valid_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (rsp_valid == req_d));

   // R8: fields hold over an idle clock
   p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !req_d) |-> ($stable(rsp_addr) && $stable(rsp_kind) && $stable(rsp_miss)));

   // R7: a miss drives nothing
   p_miss_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_miss) |-> (rsp_kind == KIND_NONE && rsp_addr == '0 && rsp_win == '0));

   // R7: miss exactly when no window matched
   p_miss_nohit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && req_d) |-> (rsp_miss == (hit_d == '0)));

   // R4: the winner matched and no lower window matched
   p_lowest_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && req_d && !rsp_miss) |-> (hit_d[rsp_win] && ((hit_d & below) == '0)));

   // R5: the I/O window reports I/O cycles, others never do
   p_io_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_miss) |-> ((rsp_win == IDX_W'(IO_WIN)) == (rsp_kind == KIND_IO)));

   // R6: configuration addresses are word aligned
   p_cfg_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_kind == KIND_CFG) |-> (rsp_addr[1:0] == 2'b00));

endmodule

bind addr_window_xlate addr_window_xlate_chk #(
   .NUM_WIN (NUM_WIN),
   .ADDR_W  (ADDR_W),
   .IO_WIN  (IO_WIN)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .hit_vec   (hit_vec),
   .rsp_valid (rsp_valid),
   .rsp_addr  (rsp_addr),
   .rsp_kind  (rsp_kind),
   .rsp_miss  (rsp_miss),
   .rsp_win   (rsp_win)
);

// File: tb/addr_window_xlate_test.sv
module addr_window_xlate_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_win = '0;
   logic        cfg_is_map = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        rsp_valid;
   logic [31:0] rsp_addr;
   logic [1:0]  rsp_kind;
   logic        rsp_miss;
   logic [1:0]  rsp_win;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #4 clk = ~clk; // 125 MHz

   addr_window_xlate uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_win    (cfg_win),
      .cfg_is_map (cfg_is_map),
      .cfg_wdata  (cfg_wdata),
      .req_valid  (req_valid),
      .req_addr   (req_addr),
      .rsp_valid  (rsp_valid),
      .rsp_addr   (rsp_addr),
      .rsp_kind   (rsp_kind),
      .rsp_miss   (rsp_miss),
      .rsp_win    (rsp_win)
   );

   // behavioural reference model
   logic [31:0] m_base [3];
   logic [31:0] m_map  [3];
   logic        e_valid = 1'b0;
   logic [31:0] e_addr = '0;
   logic [1:0]  e_kind = '0;
   logic        e_miss = 1'b0;
   logic [1:0]  e_win = '0;

   task automatic model_xlate(input logic [31:0] a);
      e_miss = 1'b1; e_addr = '0; e_kind = 2'b00; e_win = '0;
      for (int i = 0; i < 3; i++) begin
         int n;
         logic [31:0] mk;
         n  = int'(m_base[i][4:0]);
         if (n < 12) n = 12;
         mk = 32'hFFFF_FFFF << n;
         if (e_miss && m_base[i][8] && ((a & mk) == (m_base[i] & mk))) begin
            e_miss = 1'b0;
            e_win  = 2'(i);
            e_addr = (m_map[i] & mk) | (a & ~mk);
            if (i == 2) e_kind = 2'b10;
            else if (m_map[i][0]) begin
               e_kind = 2'b11;
               e_addr[1:0] = 2'b00;
            end else e_kind = 2'b01;
         end
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 3; i++) begin
            m_base[i] = '0;
            m_map[i]  = '0;
         end
         e_valid = 1'b0; e_addr = '0; e_kind = '0; e_miss = 1'b0; e_win = '0;
      end else begin
         e_valid = req_valid;
         if (req_valid) model_xlate(req_addr);
         if (cfg_we && cfg_win < 2'd3) begin
            if (cfg_is_map) m_map[cfg_win] = cfg_wdata;
            else            m_base[cfg_win] = cfg_wdata;
         end
      end
   end

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // R8 and all others: model comparison on every clock
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R8", "model valid", 32'(rsp_valid), 32'(e_valid));
         chk("R8", "model addr",  rsp_addr, e_addr);
         chk("R8", "model kind",  32'(rsp_kind), 32'(e_kind));
         chk("R8", "model miss",  32'(rsp_miss), 32'(e_miss));
         chk("R8", "model win",   32'(rsp_win), 32'(e_win));
      end
   end

   task automatic wr(input logic [1:0] w, input logic is_map, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_win = w; cfg_is_map = is_map; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic expect_rsp(input string tag, input logic m, input logic [1:0] k,
                             input logic [31:0] a, input logic [1:0] w);
      chk(tag, "valid", 32'(rsp_valid), 32'd1);
      chk(tag, "miss",  32'(rsp_miss), 32'(m));
      chk(tag, "kind",  32'(rsp_kind), 32'(k));
      chk(tag, "addr",  rsp_addr, a);
      chk(tag, "win",   32'(rsp_win), 32'(w));
   endtask

   task automatic req(input logic [31:0] ra, input string tag, input logic m,
                      input logic [1:0] k, input logic [31:0] a, input logic [1:0] w);
      @(negedge clk);
      req_valid = 1'b1; req_addr = ra;
      @(negedge clk);
      req_valid = 1'b0;
      expect_rsp(tag, m, k, a, w);
   endtask

   initial begin : watchdog
      while (!done && cycles < 5000) begin
         @(posedge clk);
         cycles++;
      end
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "reset valid", 32'(rsp_valid), 32'd0);
      chk("R1", "reset addr",  rsp_addr, 32'd0);
      rst_n = 1'b1;
      req(32'h4000_0000, "R1", 1'b1, 2'b00, 32'h0, 2'd0);

      // R9: write and request on the same edge use old contents
      @(negedge clk);
      cfg_we = 1'b1; cfg_win = 2'd0; cfg_is_map = 1'b0; cfg_wdata = 32'h4000_011C;
      req_valid = 1'b1; req_addr = 32'h4123_4567;
      @(negedge clk);
      cfg_we = 1'b0; req_valid = 1'b0;
      expect_rsp("R9", 1'b1, 2'b00, 32'h0, 2'd0);
      req(32'h4123_4567, "R9", 1'b0, 2'b01, 32'h0123_4567, 2'd0);

      wr(2'd0, 1'b1, 32'h0000_0000);
      wr(2'd1, 1'b0, 32'h5000_011C);
      wr(2'd1, 1'b1, 32'h8000_0000);
      wr(2'd2, 1'b0, 32'h6000_0118);
      wr(2'd2, 1'b1, 32'h0000_0001);
      // R3: translation joins map upper bits with offset
      req(32'h5ABC_0000, "R3", 1'b0, 2'b01, 32'h8ABC_0000, 2'd1);
      // R5: I/O window reports I/O even with map bit 0 set
      req(32'h6000_1234, "R5", 1'b0, 2'b10, 32'h0000_1234, 2'd2);
      // R7: outside all windows
      req(32'h6100_0000, "R7", 1'b1, 2'b00, 32'h0, 2'd0);

      // R8: idle clocks hold fields and drop valid
      repeat (2) @(negedge clk);
      chk("R8", "idle valid", 32'(rsp_valid), 32'd0);
      chk("R8", "idle miss held", 32'(rsp_miss), 32'd1);

      // R4: grown window 0 shadows window 1
      wr(2'd0, 1'b0, 32'h4000_011D);
      req(32'h5000_0010, "R4", 1'b0, 2'b01, 32'h1000_0010, 2'd0);
      // R5/R6: window 1 as configuration aperture
      wr(2'd1, 1'b0, 32'h6100_0118);
      wr(2'd1, 1'b1, 32'h0000_0001);
      req(32'h6100_0A13, "R6", 1'b0, 2'b11, 32'h0000_0A10, 2'd1);
      req(32'h6100_F9FE, "R6", 1'b0, 2'b11, 32'h0000_F9FC, 2'd1);
      // R10: index 3 is not a window
      wr(2'd3, 1'b0, 32'h0000_0000);
      wr(2'd3, 1'b1, 32'h0000_0000);
      req(32'h6100_0A13, "R10", 1'b0, 2'b11, 32'h0000_0A10, 2'd1);

      // restore: window 1 memory, window 0 back to 256 MB
      wr(2'd1, 1'b0, 32'h5000_011C);
      wr(2'd1, 1'b1, 32'h8000_0000);
      wr(2'd0, 1'b0, 32'h4000_011C);
      req(32'h5ABC_0000, "R4", 1'b0, 2'b01, 32'h8ABC_0000, 2'd1);

      // R4: window 2 overlapping window 0 loses
      wr(2'd2, 1'b0, 32'h4000_0118);
      wr(2'd2, 1'b1, 32'h0070_0000);
      req(32'h4000_0010, "R4", 1'b0, 2'b01, 32'h0000_0010, 2'd0);

      // R2: disabled window misses
      wr(2'd2, 1'b0, 32'h6000_0018);
      req(32'h6000_1234, "R2", 1'b1, 2'b00, 32'h0, 2'd0);
      // R2/R3: size below 4 KB clamps to 4 KB, low map bits dropped
      wr(2'd2, 1'b0, 32'h6000_0104);
      wr(2'd2, 1'b1, 32'h0030_0FFF);
      req(32'h6000_0FFC, "R2", 1'b0, 2'b10, 32'h0030_0FFC, 2'd2);
      req(32'h6000_1000, "R2", 1'b1, 2'b00, 32'h0, 2'd0);

      // R1: reset again disables every window
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      req(32'h4123_4567, "R1", 1'b1, 2'b00, 32'h0, 2'd0);

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule